// File: doc/BRIEF.md
# Frame Byte-to-Word Packer with Minimum-Length Padding

This block sits between a byte-oriented transmit source and a data port that is 8 or 16 bits wide. A frame arrives as a valid/ready byte stream. The stream marks the end of the frame, and it may contain empty beats where a chunk of zero length was handed over. In narrow mode each byte leaves as one port write. In wide mode bytes are paired into words, and the pairing runs straight across chunk boundaries. One unpaired byte is held between beats. At the end of the frame, a held byte is flushed with a zero upper byte.

A frame shorter than the minimum payload length (60 bytes by default: 64 less the 4-byte CRC) is extended with zeros. The zeros go out as single bytes in narrow mode and as whole zero words in wide mode. When the last port write has been accepted, the block raises a one-cycle done pulse that carries the padded length. The width mode is taken from its input on the first beat of each frame and held for the rest of that frame.

Top module: `frame_packer`

## Requirements
- R1: In narrow mode (`wideMode`=0 at frame start) every data byte produces one write, in arrival order. The byte is on `outData[7:0]`, `outData[15:8]` is zero and `outWide`=0.
- R2: In wide mode every two consecutive data bytes produce one write with `outWide`=1. The earlier byte is on `outData[7:0]` and the later byte is on `outData[15:8]`, also when the two bytes arrive in different chunks.
- R3: A beat with `inKeep`=0 carries no byte. It causes no write, does not count toward the length and leaves any held byte in place.
- R4: In wide mode, a frame with an odd number of data bytes ends with the word {8'h00, last byte}.
- R5: A frame with fewer than 60 bytes is padded with zeros to 60. Narrow mode writes zero bytes. Wide mode writes zero words, and the zero byte of an R4 flush counts toward the 60.
- R6: After the last write of a frame has been accepted and before the next frame's first write, `doneValid` is high for exactly one cycle. At that time `doneCount` equals the larger of the data length and 60.
- R7: The mode is sampled on the first accepted beat of a frame. Changes on `wideMode` later in the frame have no effect on that frame.
- R8: Once `outValid` is high, it stays high and `outData` and `outWide` stay stable until a cycle with `outReady` high.
- R9: `inReady` is low while a write is waiting on the port.
- R10: After reset, `outValid` and `doneValid` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high together with inValid |
| inData | input | 8 | Input byte |
| inKeep | input | 1 | Beat carries a byte (0 = empty chunk marker) |
| inLast | input | 1 | Beat is the last of the frame |
| wideMode | input | 1 | 1 = 16-bit port, 0 = 8-bit port; sampled at frame start |
| outValid | output | 1 | Port write pending |
| outReady | input | 1 | Port accepts the pending write |
| outData | output | 16 | Port write data |
| outWide | output | 1 | Write is a 16-bit word access |
| doneValid | output | 1 | One-cycle end-of-frame pulse |
| doneCount | output | 16 | Padded frame length, valid with doneValid |

## Verification
The bench targets odd-length wide frames above and below the minimum. A design that forgot the flush, or did not count its zero byte as padding, would drop a byte or emit an extra zero word. Empty beats are placed between the two halves of a pair and on the closing beat. A design that cleared the held byte there would lose data or misalign every later word. Other cases are a zero-byte frame, mode flips in the middle of a frame, and port back-pressure. These catch a design that re-reads the mode late, overwrites a pending write, or reports done before the last write has left.

// File: rtl/frame_packer_pkg.sv
package frame_packer_pkg;

  typedef enum logic {
    S_DATA = 1'b0,
    S_TAIL = 1'b1
  } packState_t;

  // Strobes from control to datapath, at most one action bit set per cycle.
  typedef struct packed {
    logic loadLeft;
    logic emitByte;
    logic emitPair;
    logic emitFlush;
    logic emitZero;
    logic wide;
  } packStrobe_t;

endpackage

// File: rtl/frame_packer_ctrl.sv
module frame_packer_ctrl
  import frame_packer_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inKeep,
  input  logic             inLast,
  input  logic             wideMode,
  input  logic             outValid,
  output logic             inReady,
  output packStrobe_t      strobe,
  output logic             doneValid,
  output logic [CNT_W-1:0] doneCount
);

  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LEN);

  packState_t       state;
  logic             inFrame;
  logic             frameWide;
  logic             haveLeft;
  logic [CNT_W-1:0] byteCnt;

  logic accept;
  logic curWide;
  logic isShort;
  logic tailGo;

  assign inReady = (state == S_DATA) && !outValid;
  assign accept  = inValid && inReady;
  assign curWide = inFrame ? frameWide : wideMode;
  assign isShort = byteCnt < MIN_CNT;
  assign tailGo  = (state == S_TAIL) && !outValid;

  always_comb begin
    strobe = '0;
    if (accept && inKeep) begin
      strobe.wide = curWide;
      if (!curWide)     strobe.emitByte = 1'b1;
      else if (haveLeft) strobe.emitPair = 1'b1;
      else               strobe.loadLeft = 1'b1;
    end else if (tailGo) begin
      strobe.wide = frameWide;
      if (haveLeft)     strobe.emitFlush = 1'b1;
      else if (isShort) strobe.emitZero  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_DATA;
      inFrame   <= 1'b0;
      frameWide <= 1'b0;
      haveLeft  <= 1'b0;
      byteCnt   <= '0;
      doneValid <= 1'b0;
      doneCount <= '0;
    end else begin
      doneValid <= 1'b0;
      if (accept) begin
        inFrame <= 1'b1;
        if (!inFrame) frameWide <= wideMode;
        if (inKeep) begin
          byteCnt <= byteCnt + 1'b1;
          if (curWide) haveLeft <= !haveLeft;
        end
        if (inLast) state <= S_TAIL;
      end else if (tailGo) begin
        if (haveLeft) begin
          haveLeft <= 1'b0;
          if (isShort) byteCnt <= byteCnt + 1'b1;
        end else if (isShort) begin
          byteCnt <= byteCnt + CNT_W'(frameWide ? 2 : 1);
        end else begin
          doneValid <= 1'b1;
          doneCount <= byteCnt;
          byteCnt   <= '0;
          inFrame   <= 1'b0;
          frameWide <= 1'b0;
          state     <= S_DATA;
        end
      end
    end
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R6: done only once nothing is left on the port or held back
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (!outValid && !haveLeft));

  // R5: the reported length never falls below the minimum
  p_done_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneCount >= MIN_CNT));

  // R3: an empty beat leaves the held byte state untouched
  p_skip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !inKeep) |=> (haveLeft == $past(haveLeft)));

  // R2: at most one datapath action per cycle
  p_one_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLeft, strobe.emitByte, strobe.emitPair,
              strobe.emitFlush, strobe.emitZero}));

endmodule

// File: rtl/frame_packer_dp.sv
module frame_packer_dp
  import frame_packer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   inData,
  input  packStrobe_t         strobe,
  input  logic                outReady,
  output logic                outValid,
  output logic [2*BYTE_W-1:0] outData,
  output logic                outWide
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] leftByte;
  logic              anyEmit;

  assign anyEmit = strobe.emitByte | strobe.emitPair | strobe.emitFlush | strobe.emitZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftByte <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outWide  <= 1'b0;
    end else begin
      if (strobe.loadLeft) leftByte <= inData;
      if (anyEmit) begin
        outValid <= 1'b1;
        outWide  <= strobe.wide;
        if (strobe.emitPair)       outData <= {inData, leftByte};
        else if (strobe.emitFlush) outData <= {{BYTE_W{1'b0}}, leftByte};
        else if (strobe.emitByte)  outData <= {{BYTE_W{1'b0}}, inData};
        else                       outData <= '0;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  // R8: a pending write holds its value until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outWide)));

  // R9: control never issues a new write over a pending one
  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !anyEmit);

  // R1: narrow writes carry a zero upper byte
  p_narrow_upper_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outWide) |-> (outData[WORD_W-1:BYTE_W] == '0));

endmodule

// File: rtl/frame_packer.sv
module frame_packer
  import frame_packer_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int MIN_LEN = 60,
  parameter int CNT_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [BYTE_W-1:0]   inData,
  input  logic                inKeep,
  input  logic                inLast,
  input  logic                wideMode,
  output logic                outValid,
  input  logic                outReady,
  output logic [2*BYTE_W-1:0] outData,
  output logic                outWide,
  output logic                doneValid,
  output logic [CNT_W-1:0]    doneCount
);

  packStrobe_t strobe;

  frame_packer_ctrl #(
    .MIN_LEN(MIN_LEN),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inKeep   (inKeep),
    .inLast   (inLast),
    .wideMode (wideMode),
    .outValid (outValid),
    .inReady  (inReady),
    .strobe   (strobe),
    .doneValid(doneValid),
    .doneCount(doneCount)
  );

  frame_packer_dp #(
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strobe  (strobe),
    .outReady(outReady),
    .outValid(outValid),
    .outData (outData),
    .outWide (outWide)
  );

endmodule

// File: tb/frame_packer_bench.sv
module frame_packer_bench;

  localparam int MIN = 60;
  localparam int NVEC = 11;
  // {stall, flip, wide, emptyAt[7:0] (255 = none), len[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'd255, 8'd64},
    {1'b1, 1'b0, 1'b0, 8'd255, 8'd10},
    {1'b0, 1'b0, 1'b1, 8'd255, 8'd64},
    {1'b1, 1'b0, 1'b1, 8'd255, 8'd61},
    {1'b0, 1'b0, 1'b1, 8'd255, 8'd59},
    {1'b1, 1'b0, 1'b1, 8'd3,   8'd57},
    {1'b0, 1'b1, 1'b1, 8'd7,   8'd7},
    {1'b0, 1'b0, 1'b1, 8'd0,   8'd0},
    {1'b1, 1'b1, 1'b0, 8'd255, 8'd60},
    {1'b0, 1'b0, 1'b1, 8'd255, 8'd1},
    {1'b0, 1'b0, 1'b1, 8'd1,   8'd2}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inKeep = 1'b0, inLast = 1'b0, wideMode = 1'b0;
  logic [7:0]  inData = '0;
  logic        inReady;
  logic        outValid, outWide, doneValid;
  logic        outReady = 1'b1;
  logic [15:0] outData, doneCount;

  frame_packer u_frame_packer (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .inKeep(inKeep), .inLast(inLast), .wideMode(wideMode),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outWide(outWide), .doneValid(doneValid), .doneCount(doneCount)
  );

  int errors = 0, checks = 0, cyc = 0, nextFrame = 0;
  bit finished = 1'b0, stallMode = 1'b0, stallAll = 1'b0;
  logic [16:0] expW[$];
  string       expTag[$];
  int          expFrame[$];
  int          expDone[$];
  int          expDoneFrame[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(int seed, int i);
    return 8'((seed * 7 + i * 13 + 5) & 255);
  endfunction

  task automatic pushW(bit w, logic [15:0] d, string tag, int fid);
    expW.push_back({w, d});
    expTag.push_back(tag);
    expFrame.push_back(fid);
  endtask

  // Expected port writes derived from the requirements alone
  task automatic planFrame(int len, bit wide, bit hasEmpty, bit flip, int seed, int fid);
    string dt;
    int bytes;
    dt = flip ? "R7" : hasEmpty ? "R3" : wide ? "R2" : "R1";
    if (!wide) begin
      for (int i = 0; i < len; i++) pushW(1'b0, {8'h00, pb(seed, i)}, dt, fid);
      for (int i = len; i < MIN; i++) pushW(1'b0, 16'h0000, "R5", fid);
    end else begin
      for (int k = 0; k + 1 < len; k += 2) pushW(1'b1, {pb(seed, k + 1), pb(seed, k)}, dt, fid);
      if (len % 2 == 1) pushW(1'b1, {8'h00, pb(seed, len - 1)}, "R4", fid);
      bytes = len + (len % 2);
      while (bytes < MIN) begin
        pushW(1'b1, 16'h0000, "R5", fid);
        bytes += 2;
      end
    end
    expDone.push_back(len > MIN ? len : MIN);
    expDoneFrame.push_back(fid);
  endtask

  task automatic sendFrame(int len, bit wide, int emptyAt, bit flip, int seed);
    bit hasEmpty;
    int nb;
    hasEmpty = (emptyAt <= len);
    nb = len + (hasEmpty ? 1 : 0);
    for (int bt = 0; bt < nb; bt++) begin
      int bi;
      bi = bt - ((hasEmpty && bt > emptyAt) ? 1 : 0);
      inValid  = 1'b1;
      inKeep   = !(hasEmpty && bt == emptyAt);
      inData   = inKeep ? pb(seed, bi) : 8'hA5;
      inLast   = (bt == nb - 1);
      wideMode = (bt == 0) ? wide : (flip ? ~wide : wide);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  // Port side: drives back-pressure and compares every accepted write
  always @(negedge clk) begin
    if (!rstN) begin
      outReady = 1'b1;
    end else begin
      cyc++;
      outReady = stallAll ? 1'b0 : (stallMode ? (cyc % 3 != 0) : 1'b1);
      if (outValid && outReady) begin
        if (expW.size() == 0) begin
          check(1'b0, "R5", "unexpected write", int'(outData), 0);
        end else begin
          logic [16:0] e;
          string t;
          int f;
          e = expW.pop_front();
          t = expTag.pop_front();
          f = expFrame.pop_front();
          check({outWide, outData} == e, t, "port write", int'({outWide, outData}), int'(e));
        end
      end
      if (doneValid) begin
        if (expDone.size() == 0) begin
          check(1'b0, "R6", "unexpected done", int'(doneCount), 0);
        end else begin
          int dc, df;
          dc = expDone.pop_front();
          df = expDoneFrame.pop_front();
          check(int'(doneCount) == dc, "R6", "done count", int'(doneCount), dc);
          check(expFrame.size() == 0 || expFrame[0] != df, "R6", "done before last write",
                expW.size(), 0);
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog: actual=hang expected=frame completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R10", "outValid in reset", int'(outValid), 0);
    check(doneValid == 1'b0, "R10", "doneValid in reset", int'(doneValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R10", "inReady after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R10", "outValid after reset", int'(outValid), 0);

    for (int v = 0; v < NVEC; v++) begin
      int len, emptyAt, fid;
      bit wide, flip;
      len      = int'(VEC[v][7:0]);
      emptyAt  = int'(VEC[v][15:8]);
      wide     = VEC[v][16];
      flip     = VEC[v][17];
      stallMode = VEC[v][18];
      fid = nextFrame++;
      planFrame(len, wide, emptyAt <= len, flip, v + 1, fid);
      sendFrame(len, wide, emptyAt, flip, v + 1);
      while (expDone.size() != 0) @(negedge clk);
      check(expW.size() == 0, "R6", "writes left after done", expW.size(), 0);
    end

    // Directed: back-pressure hold and input stall (R8, R9)
    stallMode = 1'b0;
    stallAll  = 1'b1;
    planFrame(1, 1'b0, 1'b0, 1'b0, 40, nextFrame++);
    check(inReady == 1'b1, "R9", "inReady before stall", int'(inReady), 1);
    inValid = 1'b1; inKeep = 1'b1; inLast = 1'b1; wideMode = 1'b0; inData = pb(40, 0);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    check(outValid == 1'b1, "R8", "write pending", int'(outValid), 1);
    check(inReady == 1'b0, "R9", "inReady while pending", int'(inReady), 0);
    repeat (3) @(negedge clk);
    check(outValid == 1'b1, "R8", "write still pending", int'(outValid), 1);
    check(outData == {8'h00, pb(40, 0)}, "R8", "held data", int'(outData), int'({8'h00, pb(40, 0)}));
    check(inReady == 1'b0, "R9", "inReady still low", int'(inReady), 0);
    stallAll = 1'b0;
    while (expDone.size() != 0) @(negedge clk);
    check(expW.size() == 0, "R5", "pad writes drained", expW.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule